// File: doc/BRIEF.md
# Ethernet Transmit Frame Encapsulator

This block turns a frame body held in a transmit FIFO into a complete wire-order byte stream for the physical layer. It first emits seven preamble bytes and a start delimiter. It then forwards the body bytes (destination address, source address, type/length and data) one per clock. A short body is extended with zero bytes, and a four-byte frame check sequence ends the frame.

A frame is launched only when two conditions hold together. The FIFO must either hold at least a programmed number of bytes or already contain a whole frame. The medium must also have been quiet for an inter-frame gap of twelve byte clocks. Quiet means that carrier sense is low and the block itself is not sending. The FIFO is show-ahead: the byte at its head and a last-byte flag are visible without a read, and the read strobe consumes that byte on the clock edge.

Top module: `eth_tx_encap`

## Requirements
- R1: Every frame begins with seven bytes of 0x55 followed by one byte of 0xD5 on `tx_data`, with `tx_valid` high.
- R2: After the delimiter, the FIFO head byte is forwarded on `tx_data`, one byte per clock and in FIFO order. `fifo_rd_en` is high exactly in those clocks, and the byte flagged by `fifo_last` is the final body byte.
- R3: A body shorter than 60 bytes (a data field under 46 bytes) is followed by 0x00 bytes until 60 body bytes have been sent. A body of 60 bytes or more gets no padding.
- R4: The body and pad bytes are followed by four check bytes, least-significant byte first. They are the bitwise complement of a reflected CRC-32 (polynomial 0xEDB88320, preset to all ones, bytes fed least-significant bit first) computed over all body and pad bytes.
- R5: A frame starts only when `fifo_level` is at least `cfg_threshold` or `fifo_frame_ready` is high. Otherwise the block stays idle, whatever the FIFO holds.
- R6: A frame starts only after twelve consecutive clocks in which `crs` was low and `tx_valid` was low. While `crs` is high no frame starts.
- R7: During and after reset, `tx_valid` and `fifo_rd_en` are low.
- R8: `tx_valid` stays high without a gap from the first preamble byte to the last check byte, and drops on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_threshold | input | LVL_W | FIFO fill level that allows a start |
| fifo_level | input | LVL_W | Current number of bytes in the FIFO |
| fifo_frame_ready | input | 1 | FIFO holds at least one whole frame |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_last | input | 1 | FIFO head byte is the last of its frame |
| fifo_rd_en | output | 1 | Consume the FIFO head byte |
| crs | input | 1 | Carrier sense from the medium |
| tx_valid | output | 1 | `tx_data` carries a frame byte |
| tx_data | output | 8 | Encapsulated frame byte |

## Verification
The checks assume that once a frame has started, the FIFO never runs dry before that frame's last byte. They also assume that `fifo_level` and `fifo_frame_ready` reflect what has actually been written. The stimulus either writes a whole frame before it can start, or keeps the writer ahead of the reader: it only lets the fill threshold trigger when at least 40 bytes are buffered and then adds one byte per clock. Carrier sense is held high only while the block is idle, so collision behaviour never arises.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    localparam int unsigned PRE_BYTES = 7;
    localparam int unsigned MIN_BODY  = 60;
    localparam int unsigned FCS_BYTES = 4;

    localparam logic [7:0]  PRE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE = 8'hD5;
    localparam logic [7:0]  PAD_BYTE = 8'h00;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_BODY,
        ST_PAD,
        ST_FCS
    } tx_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } tx_beat_t;

    // One byte through the reflected CRC-32, lsb first
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_gap.sv
module eth_tx_gap #(
    parameter int unsigned IFG_BYTES = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic crs,
    input  logic busy,
    output logic gap_ok
);
    localparam int unsigned GAP_W = $clog2(IFG_BYTES + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(IFG_BYTES);

    logic [GAP_W-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= '0;
        end else if (crs || busy) begin
            quiet_q <= '0;
        end else if (quiet_q != GAP_MAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign gap_ok = (quiet_q == GAP_MAX);

    AST_GAP_RESTART: assert property (@(posedge clk) disable iff (rst)
        (crs || busy) |=> !gap_ok); // R6

endmodule

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= CRC_INIT;
        end else if (en) begin
            crc_q <= crc32_step(crc_q, din);
        end
    end

    assign crc = crc_q;

    AST_CRC_PRESET: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc == CRC_INIT)); // R4

endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
    import eth_tx_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  fifo_data,
    input  logic        fifo_last,
    input  logic [31:0] crc,
    output logic        fifo_rd_en,
    output logic        crc_clr,
    output logic        crc_en,
    output tx_beat_t    beat
);
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_BYTES - 1);
    localparam logic [CNT_W-1:0] BODY_LAST = CNT_W'(MIN_BODY - 1);
    localparam logic [CNT_W-1:0] FCS_LAST  = CNT_W'(FCS_BYTES - 1);

    tx_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      fcs;
    logic [7:0]       fcs_byte;

    assign fcs = ~crc;

    always_comb begin
        case (cnt_q[1:0])
            2'd0:    fcs_byte = fcs[7:0];
            2'd1:    fcs_byte = fcs[15:8];
            2'd2:    fcs_byte = fcs[23:16];
            default: fcs_byte = fcs[31:24];
        endcase
    end

    always_comb begin
        beat       = '{valid: 1'b0, data: 8'h00};
        fifo_rd_en = 1'b0;
        crc_clr    = 1'b0;
        crc_en     = 1'b0;
        case (st_q)
            ST_PRE:  beat = '{valid: 1'b1, data: PRE_BYTE};
            ST_SFD: begin
                beat    = '{valid: 1'b1, data: SFD_BYTE};
                crc_clr = 1'b1;
            end
            ST_BODY: begin
                beat       = '{valid: 1'b1, data: fifo_data};
                fifo_rd_en = 1'b1;
                crc_en     = 1'b1;
            end
            ST_PAD: begin
                beat   = '{valid: 1'b1, data: PAD_BYTE};
                crc_en = 1'b1;
            end
            ST_FCS:  beat = '{valid: 1'b1, data: fcs_byte};
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    st_q  <= ST_PRE;
                    cnt_q <= '0;
                end
                ST_PRE: begin
                    if (cnt_q == PRE_LAST) begin
                        st_q <= ST_SFD;
                    end
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_SFD: begin
                    st_q  <= ST_BODY;
                    cnt_q <= '0;
                end
                ST_BODY: begin
                    if (fifo_last) begin
                        if (cnt_q < BODY_LAST) begin
                            st_q  <= ST_PAD;
                            cnt_q <= cnt_q + 1'b1;
                        end else begin
                            st_q  <= ST_FCS;
                            cnt_q <= '0;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PAD: begin
                    if (cnt_q == BODY_LAST) begin
                        st_q  <= ST_FCS;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_FCS: begin
                    if (cnt_q == FCS_LAST) begin
                        st_q <= ST_IDLE;
                    end
                    cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_MIN_BODY: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FCS && $past(st_q) != ST_FCS) |-> ($past(cnt_q) >= BODY_LAST)); // R3

    AST_END_FROM_FCS: assert property (@(posedge clk) disable iff (rst)
        $fell(beat.valid) |-> ($past(st_q) == ST_FCS)); // R8

endmodule

// File: rtl/eth_tx_encap.sv
module eth_tx_encap
    import eth_tx_pkg::*;
#(
    parameter int unsigned LVL_W     = 12,
    parameter int unsigned IFG_BYTES = 12,
    parameter int unsigned MAX_FRAME = 1518
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] cfg_threshold,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             fifo_frame_ready,
    input  logic [7:0]       fifo_data,
    input  logic             fifo_last,
    output logic             fifo_rd_en,
    input  logic             crs,
    output logic             tx_valid,
    output logic [7:0]       tx_data
);
    localparam int unsigned CNT_W = $clog2(MAX_FRAME + 1);

    logic        gap_ok;
    logic        start;
    logic        crc_clr;
    logic        crc_en;
    logic [31:0] crc;
    tx_beat_t    beat;

    assign start = gap_ok && ((fifo_level >= cfg_threshold) || fifo_frame_ready);

    eth_tx_gap #(
        .IFG_BYTES(IFG_BYTES)
    ) u_gap (
        .clk   (clk),
        .rst   (rst),
        .crs   (crs),
        .busy  (beat.valid),
        .gap_ok(gap_ok)
    );

    eth_tx_crc u_crc (
        .clk(clk),
        .rst(rst),
        .clr(crc_clr),
        .en (crc_en),
        .din(beat.data),
        .crc(crc)
    );

    eth_tx_ctrl #(
        .CNT_W(CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .fifo_data (fifo_data),
        .fifo_last (fifo_last),
        .crc       (crc),
        .fifo_rd_en(fifo_rd_en),
        .crc_clr   (crc_clr),
        .crc_en    (crc_en),
        .beat      (beat)
    );

    assign tx_valid = beat.valid;
    assign tx_data  = beat.data;

    AST_PREAMBLE_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_data == PRE_BYTE)); // R1

    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(fifo_frame_ready || (fifo_level >= cfg_threshold))); // R5

    AST_GAP_MET: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(gap_ok)); // R6

    AST_READ_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |-> (tx_valid && $past(tx_valid))); // R2

endmodule

// File: tb/tb_eth_tx_encap.sv
module tb_eth_tx_encap;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cfg_threshold = 12'd4000;
    logic [11:0] fifo_level;
    logic        fifo_frame_ready;
    logic [7:0]  fifo_data;
    logic        fifo_last;
    logic        fifo_rd_en;
    logic        crs = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;

    always #5 clk = ~clk;

    // Bench FIFO: show-ahead array with integer pointers
    logic [7:0] mem   [0:2047];
    logic       lastm [0:2047];
    int wr_ptr = 0, rd_ptr = 0, wr_frames = 0, rd_frames = 0;

    assign fifo_level       = 12'(wr_ptr - rd_ptr);
    assign fifo_frame_ready = (wr_frames != rd_frames);
    assign fifo_data        = mem[rd_ptr % 2048];
    assign fifo_last        = lastm[rd_ptr % 2048];

    always @(posedge clk) begin
        if (!rst && fifo_rd_en) begin
            if (lastm[rd_ptr % 2048]) rd_frames <= rd_frames + 1;
            rd_ptr <= rd_ptr + 1;
        end
    end

    eth_tx_encap dut (
        .clk             (clk),
        .rst             (rst),
        .cfg_threshold   (cfg_threshold),
        .fifo_level      (fifo_level),
        .fifo_frame_ready(fifo_frame_ready),
        .fifo_data       (fifo_data),
        .fifo_last       (fifo_last),
        .fifo_rd_en      (fifo_rd_en),
        .crs             (crs),
        .tx_valid        (tx_valid),
        .tx_data         (tx_data)
    );

    int total = 0, bad = 0, cycles = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            if (r[0] != b[k]) r = (r >> 1) ^ 32'hEDB88320;
            else              r = r >> 1;
        end
        return r;
    endfunction

    // Reference model, advanced once per clock at the falling edge
    int          phase = 0;   // 0 idle, 1 header, 2 body, 3 tail
    int          gap_m = 0;
    int          m_ptr = 0;
    int          nbody = 0;
    logic [31:0] crc_m;
    logic [7:0]  m_q[$];
    string       m_tag[$];

    always @(negedge clk) begin
        bit         exp_v;
        bit         go;
        logic [7:0] eb;
        string      et;
        logic [31:0] fcs;
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (rst) begin
            phase = 0; gap_m = 0; m_ptr = 0;
            m_q.delete(); m_tag.delete();
        end else begin
            exp_v = (phase != 0);
            eb = 8'h00; et = "";
            if (phase == 2) begin
                eb = mem[m_ptr % 2048]; et = "R2";
            end else if (phase != 0) begin
                eb = m_q[0]; et = m_tag[0];
            end
            chk(tx_valid == exp_v, "R8 R5 R6 tx_valid", int'(tx_valid), int'(exp_v));
            chk(fifo_rd_en == (phase == 2), "R2 fifo_rd_en", int'(fifo_rd_en), int'(phase == 2));
            if (exp_v) chk(tx_data == eb, et, int'(tx_data), int'(eb));

            go = (phase == 0) && (gap_m == 12) &&
                 ((fifo_level >= cfg_threshold) || fifo_frame_ready);
            if (crs || exp_v) gap_m = 0;
            else if (gap_m < 12) gap_m++;

            case (phase)
                1: begin
                    void'(m_q.pop_front()); void'(m_tag.pop_front());
                    if (m_q.size() == 0) begin
                        phase = 2; crc_m = 32'hFFFFFFFF; nbody = 0;
                    end
                end
                2: begin
                    crc_m = ref_crc(crc_m, mem[m_ptr % 2048]);
                    nbody++;
                    if (lastm[m_ptr % 2048]) begin
                        while (nbody < 60) begin
                            m_q.push_back(8'h00); m_tag.push_back("R3");
                            crc_m = ref_crc(crc_m, 8'h00);
                            nbody++;
                        end
                        fcs = ~crc_m;
                        for (int k = 0; k < 4; k++) begin
                            m_q.push_back(fcs[8*k +: 8]); m_tag.push_back("R4");
                        end
                        phase = 3;
                    end
                    m_ptr++;
                end
                3: begin
                    void'(m_q.pop_front()); void'(m_tag.pop_front());
                    if (m_q.size() == 0) phase = 0;
                end
                default: ;
            endcase

            if (go) begin
                for (int k = 0; k < 7; k++) begin
                    m_q.push_back(8'h55); m_tag.push_back("R1");
                end
                m_q.push_back(8'hD5); m_tag.push_back("R1");
                phase = 1;
            end
        end
    end

    task automatic put_bytes(input int first, input int count, input int len, input int seed);
        for (int i = first; i < first + count; i++) begin
            @(posedge clk); #2;
            mem[wr_ptr % 2048]   = 8'((seed + i * 37 + (i >> 2)) & 8'hFF);
            lastm[wr_ptr % 2048] = (i == len - 1);
            wr_ptr++;
            if (i == len - 1) wr_frames++;
        end
    endtask

    task automatic wait_done();
        int guard;
        guard = 0;
        do begin
            @(negedge clk); #1;
            guard++;
        end while ((phase != 0 || wr_ptr != rd_ptr) && guard < 5000);
        repeat (3) @(posedge clk);
        #2;
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mem[i] = 8'h00; lastm[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: outputs quiet while reset is held
        chk(tx_valid == 1'b0, "R7 tx_valid in reset", int'(tx_valid), 0);
        chk(fifo_rd_en == 1'b0, "R7 fifo_rd_en in reset", int'(fifo_rd_en), 0);
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R7 tx_valid after reset", int'(tx_valid), 0);

        // R3: short body padded, started by whole-frame flag (R5)
        cfg_threshold = 12'd4000;
        put_bytes(0, 20, 20, 3);
        wait_done();

        // R3: exactly 60 body bytes, no pad
        put_bytes(0, 60, 60, 91);
        wait_done();

        // R3: 59 body bytes, one pad byte
        put_bytes(0, 59, 59, 17);
        wait_done();

        // R5: below threshold and incomplete frame stays idle
        cfg_threshold = 12'd40;
        put_bytes(0, 5, 70, 55);
        repeat (30) begin
            @(negedge clk);
            chk(tx_valid == 1'b0, "R5 idle below threshold", int'(tx_valid), 0);
        end
        put_bytes(5, 65, 70, 55);
        wait_done();

        // R6: carrier sense holds off a ready frame
        cfg_threshold = 12'd4000;
        @(posedge clk); #2;
        crs = 1'b1;
        put_bytes(0, 30, 30, 200);
        repeat (20) begin
            @(negedge clk);
            chk(tx_valid == 1'b0, "R6 held off by carrier", int'(tx_valid), 0);
        end
        @(posedge clk); #2;
        crs = 1'b0;
        wait_done();

        // R6 R8: back-to-back frames keep the gap after own transmission
        put_bytes(0, 64, 64, 9);
        put_bytes(0, 25, 25, 130);
        wait_done();

        // R2: long body forwarded intact
        put_bytes(0, 100, 100, 77);
        wait_done();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule